// File: doc/BRIEF.md
# Sample-Hold Extrapolator (Zero / First Order)

This block turns a stream of binary sample codes into a finer-grained output that fills the time between sampling instants. A code arrives with a strobe once per sampling interval. The block scales it to a value proportional to the reference, and then steps the output forward on every fine-rate tick until the next strobe arrives.

Two hold orders are available. The zero-order hold keeps the output flat for the whole interval. The first-order hold extrapolates in a straight line. Its slope is the difference between the newest decoded value and the one before it, divided by the interval length. The output therefore heads toward where the next sample is predicted to land, and it does not interpolate toward a sample that is already known.

Internally the output is a signed fixed-point word. It has `CODE_W + T_LOG2` fractional bits, so one code step divided by the interval length is represented exactly. The interval length `T = 2**T_LOG2` ticks is a power of two, which makes the division a plain shift.

Top module: `zfoh_extrap`

## Requirements
- R1: One clock after a strobe, `out_val` equals `REF_SCALE * code * 2**T_LOG2`. In real units this is `REF_SCALE * code / 2**CODE_W`, with `CODE_W + T_LOG2` fractional bits.
- R2: While the zero-order hold is active, the output stays at the value loaded at the interval start, whatever ticks arrive.
- R3: While the first-order hold is active, the output one clock after the k-th tick of an interval equals `base + k * (base - prev) / T`. Here `base` is the value loaded at the interval start and `prev` is the value loaded at the strobe before it.
- R4: The first strobe after reset has no predecessor, so its slope is zero and the first-order output stays flat.
- R5: The output never leaves the range from 0 to `REF_SCALE * 2**(CODE_W+T_LOG2)`. An extrapolated value beyond either end is clamped to that end.
- R6: `mode_sel` (0 = zero-order, 1 = first-order) is sampled only on a strobe. Changing it inside an interval has no effect until the next strobe.
- R7: At most `T-1` ticks advance the ramp within one interval. Further ticks before the next strobe leave the output unchanged.
- R8: When a strobe and a tick arrive in the same cycle, the strobe wins. The output loads the new decoded value and does not ramp in that cycle.
- R9: While `rst` is high, the output is cleared to 0 one clock later, and the memory of the previous sample is discarded.
- R10: In a cycle with neither a strobe nor a tick, the output does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | Sample strobe; marks a new sampling instant |
| smp_code | input | CODE_W | Binary sample code, taken when `smp_stb` is high |
| fine_tick | input | 1 | Fine-rate tick that advances the output within an interval |
| mode_sel | input | 1 | Hold order: 0 zero-order, 1 first-order; taken on a strobe |
| out_val | output | OUT_W | Signed fixed-point output |

## Verification
Every result of this block lands exactly one clock after the edge that takes the stimulus. A strobe's decoded value and a tick's ramp step are both due at that point, because there is only one register between the inputs and `out_val`. The bench drives each strobe or tick for a single clock edge and reads `out_val` a quarter period after that edge, so each check sees the result of exactly one edge. The bench also runs idle cycles and mid-interval mode flips, and checks on the following edge that the output has not moved.

// File: rtl/zfoh_pkg.sv
package zfoh_pkg;

    typedef enum logic {
        HOLD_ZERO  = 1'b0,
        HOLD_FIRST = 1'b1
    } hold_mode_e;

    // fractional bits: one code step divided by the interval length
    function automatic int frac_bits(input int code_w, input int t_log2);
        return code_w + t_log2;
    endfunction

    // accumulator width: reference magnitude, fraction, one headroom bit, sign
    function automatic int acc_bits(input int ref_scale, input int code_w, input int t_log2);
        return $clog2(ref_scale + 1) + frac_bits(code_w, t_log2) + 2;
    endfunction

endpackage

// File: rtl/zfoh_tick_ctr.sv
module zfoh_tick_ctr #(
    parameter int T_LOG2 = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic tick,
    output logic adv
);
    localparam logic [T_LOG2-1:0] LAST = '1;

    logic [T_LOG2-1:0] cnt;

    // ramp advances only on a tick that is not pre-empted by a strobe,
    // and only while the interval has steps left
    assign adv = tick && !restart && (cnt != LAST);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/zfoh_slope_unit.sv
module zfoh_slope_unit #(
    parameter int CODE_W    = 6,
    parameter int T_LOG2    = 3,
    parameter int REF_SCALE = 100,
    parameter int ACC_W     = 18
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic [CODE_W-1:0]       code,
    output logic signed [ACC_W-1:0] raw_now,
    output logic signed [ACC_W-1:0] slope_next
);
    localparam logic [ACC_W-1:0] REF_V = ACC_W'(REF_SCALE);

    logic [ACC_W-1:0]        prod;
    logic signed [ACC_W-1:0] prev_raw;
    logic                    primed;
    logic signed [ACC_W-1:0] diff;

    // decoded value = REF * code / 2^CODE_W, held with CODE_W+T_LOG2 fraction bits
    assign prod    = REF_V * ACC_W'(code);
    assign raw_now = signed'(prod << T_LOG2);

    // no predecessor after reset: treat previous as equal to current
    assign diff       = primed ? (raw_now - prev_raw) : '0;
    assign slope_next = diff >>> T_LOG2;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_raw <= '0;
            primed   <= 1'b0;
        end else if (load) begin
            prev_raw <= raw_now;
            primed   <= 1'b1;
        end
    end
endmodule

// File: rtl/zfoh_ramp_out.sv
module zfoh_ramp_out
    import zfoh_pkg::*;
#(
    parameter int ACC_W      = 18,
    parameter int FULL_SCALE = 51200
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic                    adv,
    input  hold_mode_e              mode_in,
    input  logic signed [ACC_W-1:0] load_val,
    input  logic signed [ACC_W-1:0] slope_in,
    output logic signed [ACC_W-1:0] out_val,
    output hold_mode_e              mode_q
);
    localparam logic signed [ACC_W-1:0] FULL_V = ACC_W'(FULL_SCALE);

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] slope_q;
    logic signed [ACC_W-1:0] acc_step;
    logic signed [ACC_W-1:0] acc_clamped;

    assign acc_step = acc + slope_q;

    always_comb begin
        if (acc_step < 0) begin
            acc_clamped = '0;
        end else if (acc_step > FULL_V) begin
            acc_clamped = FULL_V;
        end else begin
            acc_clamped = acc_step;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            slope_q <= '0;
            out_val <= '0;
            mode_q  <= HOLD_ZERO;
        end else if (load) begin
            acc     <= load_val;
            slope_q <= slope_in;
            out_val <= load_val;
            mode_q  <= mode_in;
        end else if (adv && (mode_q == HOLD_FIRST)) begin
            acc     <= acc_step;
            out_val <= acc_clamped;
        end
    end
endmodule

// File: rtl/zfoh_extrap.sv
module zfoh_extrap
    import zfoh_pkg::*;
#(
    parameter int  CODE_W    = 6,
    parameter int  T_LOG2    = 3,
    parameter int  REF_SCALE = 100,
    localparam int OUT_W     = acc_bits(REF_SCALE, CODE_W, T_LOG2)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_stb,
    input  logic [CODE_W-1:0]       smp_code,
    input  logic                    fine_tick,
    input  logic                    mode_sel,
    output logic signed [OUT_W-1:0] out_val
);
    localparam int FRAC_W     = frac_bits(CODE_W, T_LOG2);
    localparam int FULL_SCALE = REF_SCALE * (2 ** FRAC_W);

    logic                    adv;
    logic signed [OUT_W-1:0] raw_now;
    logic signed [OUT_W-1:0] slope_next;
    hold_mode_e              mode_in;
    hold_mode_e              mode_act;

    assign mode_in = hold_mode_e'(mode_sel);

    zfoh_tick_ctr #(
        .T_LOG2 (T_LOG2)
    ) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .restart (smp_stb),
        .tick    (fine_tick),
        .adv     (adv)
    );

    zfoh_slope_unit #(
        .CODE_W    (CODE_W),
        .T_LOG2    (T_LOG2),
        .REF_SCALE (REF_SCALE),
        .ACC_W     (OUT_W)
    ) u_slope (
        .clk        (clk),
        .rst        (rst),
        .load       (smp_stb),
        .code       (smp_code),
        .raw_now    (raw_now),
        .slope_next (slope_next)
    );

    zfoh_ramp_out #(
        .ACC_W      (OUT_W),
        .FULL_SCALE (FULL_SCALE)
    ) u_ramp (
        .clk      (clk),
        .rst      (rst),
        .load     (smp_stb),
        .adv      (adv),
        .mode_in  (mode_in),
        .load_val (raw_now),
        .slope_in (slope_next),
        .out_val  (out_val),
        .mode_q   (mode_act)
    );
endmodule

// File: rtl/zfoh_extrap_chk.sv
module zfoh_extrap_chk
    import zfoh_pkg::*;
#(
    parameter int CODE_W    = 6,
    parameter int T_LOG2    = 3,
    parameter int REF_SCALE = 100,
    parameter int OUT_W     = 18
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    smp_stb,
    input logic [CODE_W-1:0]       smp_code,
    input logic                    fine_tick,
    input logic signed [OUT_W-1:0] out_val,
    input hold_mode_e              mode_act
);
    localparam int FULL_I = REF_SCALE * (2 ** (CODE_W + T_LOG2));

    int code_val;
    int out_i;

    always_comb begin
        code_val = REF_SCALE * int'(smp_code) * (2 ** T_LOG2);
        out_i    = int'(out_val);
    end

    a_r1_decode: assert property (@(posedge clk) disable iff (rst)
        smp_stb |=> out_i == $past(code_val));

    a_r2_zoh_hold: assert property (@(posedge clk) disable iff (rst)
        (!smp_stb && mode_act == HOLD_ZERO) |=> $stable(out_val));

    a_r5_range: assert property (@(posedge clk) disable iff (rst)
        (out_i >= 0) && (out_i <= FULL_I));

    a_r6_mode_latched: assert property (@(posedge clk) disable iff (rst)
        !smp_stb |=> $stable(mode_act));

    a_r9_reset_clear: assert property (@(posedge clk)
        rst |=> out_val == '0);

    a_r10_idle_stable: assert property (@(posedge clk) disable iff (rst)
        (!smp_stb && !fine_tick) |=> $stable(out_val));
endmodule

bind zfoh_extrap zfoh_extrap_chk #(
    .CODE_W    (CODE_W),
    .T_LOG2    (T_LOG2),
    .REF_SCALE (REF_SCALE),
    .OUT_W     (OUT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_stb   (smp_stb),
    .smp_code  (smp_code),
    .fine_tick (fine_tick),
    .out_val   (out_val),
    .mode_act  (mode_act)
);

// File: tb/tb_zfoh_extrap.sv
module tb_zfoh_extrap;
    localparam int CLK_PERIOD = 10;
    localparam int CODE_W     = 6;
    localparam int T_LOG2     = 3;
    localparam int REF_SCALE  = 100;
    localparam int T          = 2 ** T_LOG2;
    localparam int OUT_W      = $clog2(REF_SCALE + 1) + CODE_W + T_LOG2 + 2;
    localparam int FULL       = REF_SCALE * (2 ** (CODE_W + T_LOG2));
    localparam int WATCHDOG   = 20000;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    smp_stb = 1'b0;
    logic [CODE_W-1:0]       smp_code = '0;
    logic                    fine_tick = 1'b0;
    logic                    mode_sel = 1'b0;
    logic signed [OUT_W-1:0] out_val;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    int  m_base;
    int  m_prev;
    bit  m_primed;
    bit  m_first;
    int  m_k;

    zfoh_extrap #(
        .CODE_W    (CODE_W),
        .T_LOG2    (T_LOG2),
        .REF_SCALE (REF_SCALE)
    ) dut (
        .clk       (clk),
        .rst       (rst),
        .smp_stb   (smp_stb),
        .smp_code  (smp_code),
        .fine_tick (fine_tick),
        .mode_sel  (mode_sel),
        .out_val   (out_val)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int raw_of(input int code);
        return REF_SCALE * code * T;
    endfunction

    function automatic int model_out();
        int v;
        if (!m_first) return raw_of(m_base);
        v = raw_of(m_base) + m_k * ((raw_of(m_base) - raw_of(m_prev)) / T);
        if (v < 0) v = 0;
        if (v > FULL) v = FULL;
        return v;
    endfunction

    task automatic check(input string tag, input int expv);
        checks++;
        if (int'(out_val) != expv) begin
            errors++;
            $display("FAIL %s: out=%0d expected=%0d", tag, int'(out_val), expv);
        end
    endtask

    // one clock edge with the given inputs, sampled a quarter period later
    task automatic edge_cycle(input bit stb, input int code, input bit tick);
        smp_stb   = stb;
        smp_code  = CODE_W'(code);
        fine_tick = tick;
        @(posedge clk);
        #(CLK_PERIOD / 4);
        smp_stb   = 1'b0;
        fine_tick = 1'b0;
    endtask

    task automatic do_sample(input string tag, input int code, input bit first, input bit with_tick);
        mode_sel = first;
        m_prev   = m_primed ? m_base : code;
        m_base   = code;
        m_primed = 1'b1;
        m_first  = first;
        m_k      = 0;
        edge_cycle(1'b1, code, with_tick);
        check(tag, raw_of(code));
    endtask

    task automatic do_tick(input string tag);
        if (m_first && m_k < T - 1) m_k++;
        edge_cycle(1'b0, 0, 1'b1);
        check(tag, model_out());
    endtask

    task automatic do_idle(input string tag);
        edge_cycle(1'b0, 0, 1'b0);
        check(tag, model_out());
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #(CLK_PERIOD / 4);
        check("R9 reset clears output", 0);
        rst = 1'b0;
        m_primed = 1'b0;
        m_base = 0;
        m_prev = 0;
        m_first = 1'b0;
        m_k = 0;
    endtask

    task automatic t_first_sample();
        do_sample("R1 first decode", 20, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) do_tick("R4 first sample zero slope");
    endtask

    task automatic t_ramp();
        do_sample("R1 decode rising", 30, 1'b1, 1'b0);
        for (int i = 0; i < T - 1; i++) do_tick("R3 first-order ramp");
        do_tick("R7 ramp stops after T-1 ticks");
        do_tick("R7 extra tick holds");
        do_idle("R10 idle cycle holds");
    endtask

    task automatic t_falling_ramp();
        do_sample("R1 decode falling", 18, 1'b1, 1'b0);
        for (int i = 0; i < 4; i++) do_tick("R3 negative slope ramp");
    endtask

    task automatic t_zero_order();
        do_sample("R1 decode zero-order", 10, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) do_tick("R2 zero-order flat");
        do_idle("R10 idle in zero-order");
    endtask

    task automatic t_mode_midway();
        do_sample("R1 decode before mode flip", 25, 1'b1, 1'b0);
        do_tick("R3 ramp before flip");
        mode_sel = 1'b0;
        do_tick("R6 flip to zero-order ignored mid-interval");
        do_tick("R6 ramp continues after flip");
        do_sample("R1 zero-order after strobe", 40, 1'b0, 1'b0);
        mode_sel = 1'b1;
        do_tick("R6 flip to first-order ignored mid-interval");
        do_tick("R2 still flat");
    endtask

    task automatic t_saturation();
        do_sample("R1 decode top code", 63, 1'b1, 1'b0);
        do_tick("R5 clamp at full scale");
        do_tick("R5 clamp stays at full scale");
        do_sample("R1 decode low code", 2, 1'b1, 1'b0);
        do_tick("R5 clamp at zero");
        do_tick("R5 clamp stays at zero");
    endtask

    task automatic t_strobe_and_tick();
        do_sample("R8 strobe wins over tick", 50, 1'b1, 1'b1);
        do_tick("R8 ramp counts from strobe");
    endtask

    task automatic t_reset_midrun();
        do_reset();
        do_sample("R1 decode after reset", 12, 1'b1, 1'b0);
        do_tick("R4 zero slope after reset");
        do_tick("R4 zero slope after reset, second tick");
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: out=%0d expected=finish", int'(out_val));
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stimulus
        m_primed = 1'b0;
        m_base = 0;
        m_prev = 0;
        m_first = 1'b0;
        m_k = 0;
        do_reset();
        t_first_sample();
        t_ramp();
        t_falling_ramp();
        t_zero_order();
        t_mode_midway();
        t_saturation();
        t_strobe_and_tick();
        t_reset_midrun();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule